// File: doc/BRIEF.md
# Deferred Branch Reconciliation Unit

This unit sits beside the exit predictor of an in-order front end. It holds the prediction that is in flight: the target address of the next block and the number of cycles left before decode must switch to it. It counts those cycles down and raises a one-cycle transfer strobe when the count reaches zero. A deferred branch arrives from the execute side already evaluated. It carries its predicate outcome, a target address and a deferral in cycles. The unit compares that branch with the live prediction and classifies it in one of four ways: discarded, agreeing, a cheap fetch reset, or a full unwind.

On a fetch reset or a full unwind, the unit loads the deferred branch as the new pending prediction and emits a one-cycle redirect carrying the target. It then holds a busy signal that stalls issue for the recovery latency. That latency depends on whether the target hit the instruction microcache, and a full unwind also pays for the wrong-path cycles. Ordinary branches take priority. An ordinary branch that resolves while a deferred transfer is pending cancels it. Only one deferred transfer can be outstanding, and a newer one replaces the older.

Top module: `dbr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears its state. After that edge `pend_valid_o`, `xfer_o`, `redir_valid_o` and `busy_o` are 0, `act_o` is 0 (none), and `pend_target_o` and `pend_count_o` are 0.
- R2: `pred_load` with target T and duration D makes the pending prediction valid after the edge, with target T and remaining count D. The count falls by one per cycle. `xfer_o` is high in the one cycle where the count is 0, and the pending prediction is invalid from the next cycle on.
- R3: A deferred branch whose predicate is false reports `act_o` = 1 (discard) in the cycle after it is presented. It raises no redirect and leaves the pending prediction to count on unchanged.
- R4: Take a true-predicate deferred branch whose target and deferral both equal the pending target and the remaining count of that cycle. It reports `act_o` = 2 (agree), raises no redirect, and leaves the pending prediction unchanged.
- R5: A true-predicate deferred branch reports `act_o` = 3 (fetch reset) in either of two cases. One case is that no prediction is pending. The other is that the target or the deferral differs and the deferral is not below the remaining count. In the next cycle it pulses `redir_valid_o` with `redir_target_o` equal to the branch target, and loads that target and the deferral as the pending prediction.
- R6: A true-predicate deferred branch whose deferral is below the remaining count reports `act_o` = 4 (full recovery). It redirects and loads the pending prediction in the same way as R5.
- R7: After a decision, `busy_o` stays high for a set number of cycles: a fetch reset holds it for `LAT_HIT` cycles (default 3) on a microcache hit and for `LAT_MISS` cycles (default 5) on a miss. A full recovery holds it for `LAT_MISS + UNWIND` cycles (default 7) whatever the hit input.
- R8: `ob_resolve` cancels a pending deferred transfer, so the prediction becomes invalid after the edge. A deferred branch presented in the same cycle is dropped with `act_o` = 0. A pending prediction that came from `pred_load` is not affected.
- R9: A deferred branch arriving while an earlier one is pending or busy is judged against the current pending state. On a reset or recovery outcome it replaces the pending transfer and restarts the busy count.
- R10: `pred_load` has no effect while a deferred transfer is pending: target and countdown continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_load | input | 1 | Predictor installs a new exit prediction |
| pred_target | input | AW | Predicted next-block address |
| pred_dur | input | CW | Predicted cycles until the transfer |
| db_valid | input | 1 | An evaluated deferred branch is presented |
| db_pred | input | 1 | Predicate outcome of the deferred branch |
| db_target | input | AW | Deferred branch target |
| db_defer | input | CW | Deferred branch deferral in cycles |
| db_hit | input | 1 | Target hits the instruction microcache |
| ob_resolve | input | 1 | An ordinary branch resolved this cycle |
| act_o | output | 3 | Decision code: 0 none, 1 discard, 2 agree, 3 reset, 4 recovery |
| redir_valid_o | output | 1 | One-cycle fetch redirect request |
| redir_target_o | output | AW | Redirect address |
| pend_valid_o | output | 1 | A prediction is pending |
| pend_target_o | output | AW | Pending target |
| pend_count_o | output | CW | Cycles remaining on the pending prediction |
| xfer_o | output | 1 | Decode must switch to the pending target now |
| busy_o | output | 1 | Reset or recovery in progress; stall issue |

## Verification
The deferred branch is tried against a live prediction in five patterns: a false predicate, an exact match, a deferral that differs with the target unchanged, a new target with no pending prediction, and a deferral shorter than the remaining count. Together these show that each outcome follows from the correct field compare and the correct ordering. The busy window is measured after a reset that hits the microcache, a reset that misses, and a full recovery, which separates the three latencies. Further cases show which input wins when several act at once: an ordinary branch in the same cycle as a deferred branch, a predictor load while a deferred transfer is pending, and a second deferred branch during busy.

// File: rtl/dbr_pkg.sv
// Shared types for the deferred branch reconciliation unit.
package dbr_pkg;
    // Outcome of judging one deferred branch against the live prediction.
    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_DISCARD = 3'd1,
        ACT_AGREE   = 3'd2,
        ACT_RESET   = 3'd3,
        ACT_RECOVER = 3'd4
    } dbr_act_e;
endpackage

// File: rtl/dbr_compare.sv
// Purely combinational judge. It classifies a presented deferred branch
// against the pending prediction as it stands in this cycle.
// Assumes the caller registers the result; an ordinary branch resolving
// in the same cycle suppresses the judgement.
module dbr_compare
    import dbr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 6
) (
    input  logic          db_valid,
    input  logic          db_pred,
    input  logic [AW-1:0] db_target,
    input  logic [CW-1:0] db_defer,
    input  logic          ob_resolve,
    input  logic          pend_valid,
    input  logic [AW-1:0] pend_target,
    input  logic [CW-1:0] pend_count,
    output dbr_act_e      act
);
    logic same_target;
    logic same_defer;
    logic too_late;

    assign same_target = (db_target == pend_target);
    assign same_defer  = (db_defer == pend_count);
    assign too_late    = (db_defer < pend_count);

    // Pick the outcome; ordinary branch first, then predicate, then fields.
    always_comb begin
        if (!db_valid || ob_resolve) begin
            act = ACT_NONE;
        end else if (!db_pred) begin
            act = ACT_DISCARD;
        end else if (!pend_valid) begin
            act = ACT_RESET;
        end else if (same_target && same_defer) begin
            act = ACT_AGREE;
        end else if (too_late) begin
            act = ACT_RECOVER;
        end else begin
            act = ACT_RESET;
        end
    end
endmodule

// File: rtl/dbr_pending.sv
// Pending prediction registers and countdown. It holds one target and a
// remaining count, and a flag saying whether a deferred branch installed
// them. Priority: ordinary-branch cancel, deferred load, predictor load,
// countdown. A predictor load cannot displace a deferred transfer.
module dbr_pending #(
    parameter int AW = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ob_resolve,
    input  logic          load_db,
    input  logic [AW-1:0] db_target,
    input  logic [CW-1:0] db_defer,
    input  logic          pred_load,
    input  logic [AW-1:0] pred_target,
    input  logic [CW-1:0] pred_dur,
    output logic          pend_valid,
    output logic [AW-1:0] pend_target,
    output logic [CW-1:0] pend_count,
    output logic          pend_db,
    output logic          xfer
);
    logic cancel;
    logic take_pred;

    assign cancel    = ob_resolve && pend_db;
    assign take_pred = pred_load && !pend_db;
    assign xfer      = pend_valid && (pend_count == '0);

    // Update the pending prediction by fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid  <= 1'b0;
            pend_target <= '0;
            pend_count  <= '0;
            pend_db     <= 1'b0;
        end else if (cancel) begin
            pend_valid <= 1'b0;
            pend_db    <= 1'b0;
        end else if (load_db) begin
            pend_valid  <= 1'b1;
            pend_target <= db_target;
            pend_count  <= db_defer;
            pend_db     <= 1'b1;
        end else if (take_pred) begin
            pend_valid  <= 1'b1;
            pend_target <= pred_target;
            pend_count  <= pred_dur;
            pend_db     <= 1'b0;
        end else if (pend_valid) begin
            if (pend_count == '0) begin
                pend_valid <= 1'b0;
                pend_db    <= 1'b0;
            end else begin
                pend_count <= pend_count - 1'b1;
            end
        end
    end

    // R8: an ordinary branch drops a deferred transfer.
    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_resolve && pend_db) |=> !pend_valid);

    // R10: a predictor load leaves a deferred target untouched.
    a_r10_pred_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_db && pred_load && !ob_resolve && !load_db)
        |=> (pend_target == $past(pend_target)));

    // R2: an idle pending prediction counts down by one.
    a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && pend_count != '0 && !ob_resolve && !load_db && !pred_load)
        |=> (pend_count == $past(pend_count) - 1'b1));

    // R2: after the transfer cycle the prediction is gone unless reloaded.
    a_r2_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !load_db && !pred_load) |=> !pend_valid);
endmodule

// File: rtl/dbr_busy.sv
// Recovery latency timer. A start loads the latency that belongs to the
// outcome, and busy stays high until the count drains. A new start while
// busy restarts the count.
module dbr_busy #(
    parameter int LAT_HIT  = 3,
    parameter int LAT_MISS = 5,
    parameter int UNWIND   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic full_recover,
    input  logic hit,
    output logic busy
);
    localparam int MAXLAT = LAT_MISS + UNWIND;
    localparam int BW     = $clog2(MAXLAT + 1);

    logic [BW-1:0] remain;
    logic [BW-1:0] load_val;

    // Choose the stall length for this outcome.
    always_comb begin
        if (full_recover)  load_val = BW'(MAXLAT);
        else if (hit)      load_val = BW'(LAT_HIT);
        else               load_val = BW'(LAT_MISS);
    end

    // Load on start, otherwise drain toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               remain <= '0;
        else if (start)           remain <= load_val;
        else if (remain != '0)    remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R7: the timer never holds more than the longest latency.
    always_ff @(posedge clk) begin
        if (rst_n) a_r7_bound: assert (remain <= BW'(MAXLAT));
    end

    // R7: a start always makes busy visible in the next cycle.
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7: without a new start the timer only drains.
    a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && busy) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/dbr_unit.sv
// Deferred branch reconciliation top. It judges each deferred branch
// against the pending exit prediction and reports the outcome one cycle
// later. On a reset or a recovery it redirects fetch and reloads the
// prediction, and holds busy for the latency of that outcome.
module dbr_unit
    import dbr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 6,
    parameter int LAT_HIT  = 3,
    parameter int LAT_MISS = 5,
    parameter int UNWIND   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pred_load,
    input  logic [AW-1:0] pred_target,
    input  logic [CW-1:0] pred_dur,
    input  logic          db_valid,
    input  logic          db_pred,
    input  logic [AW-1:0] db_target,
    input  logic [CW-1:0] db_defer,
    input  logic          db_hit,
    input  logic          ob_resolve,
    output logic [2:0]    act_o,
    output logic          redir_valid_o,
    output logic [AW-1:0] redir_target_o,
    output logic          pend_valid_o,
    output logic [AW-1:0] pend_target_o,
    output logic [CW-1:0] pend_count_o,
    output logic          xfer_o,
    output logic          busy_o
);
    dbr_act_e      act;
    dbr_act_e      act_q;
    logic          load_db;
    logic          full_recover;
    logic          pend_db;
    logic          pend_valid;
    logic [AW-1:0] pend_target;
    logic [CW-1:0] pend_count;

    assign load_db      = (act == ACT_RESET) || (act == ACT_RECOVER);
    assign full_recover = (act == ACT_RECOVER);

    dbr_compare #(.AW(AW), .CW(CW)) u_cmp (
        .db_valid    (db_valid),
        .db_pred     (db_pred),
        .db_target   (db_target),
        .db_defer    (db_defer),
        .ob_resolve  (ob_resolve),
        .pend_valid  (pend_valid),
        .pend_target (pend_target),
        .pend_count  (pend_count),
        .act         (act)
    );

    dbr_pending #(.AW(AW), .CW(CW)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .ob_resolve  (ob_resolve),
        .load_db     (load_db),
        .db_target   (db_target),
        .db_defer    (db_defer),
        .pred_load   (pred_load),
        .pred_target (pred_target),
        .pred_dur    (pred_dur),
        .pend_valid  (pend_valid),
        .pend_target (pend_target),
        .pend_count  (pend_count),
        .pend_db     (pend_db),
        .xfer        (xfer_o)
    );

    dbr_busy #(.LAT_HIT(LAT_HIT), .LAT_MISS(LAT_MISS), .UNWIND(UNWIND)) u_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (load_db),
        .full_recover (full_recover),
        .hit          (db_hit),
        .busy         (busy_o)
    );

    // Register the outcome and the redirect request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q          <= ACT_NONE;
            redir_valid_o  <= 1'b0;
            redir_target_o <= '0;
        end else begin
            act_q          <= act;
            redir_valid_o  <= load_db;
            redir_target_o <= load_db ? db_target : redir_target_o;
        end
    end

    assign act_o         = act_q;
    assign pend_valid_o  = pend_valid;
    assign pend_target_o = pend_target;
    assign pend_count_o  = pend_count;

    // R5, R6: every redirect comes with a stall and a loaded prediction.
    a_r5_redirect_busy: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |-> (busy_o && pend_valid && pend_target == redir_target_o));

    // R3, R4: discard and agree never redirect.
    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == ACT_DISCARD || act_q == ACT_AGREE) |-> !redir_valid_o);

    // R8: a deferred branch beside an ordinary one is dropped.
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_resolve && db_valid) |=> (act_q == ACT_NONE && !redir_valid_o));
endmodule

// File: tb/dbr_unit_tb.sv
module dbr_unit_tb;
    localparam int AW = 32;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_load = 1'b0;
    logic [AW-1:0] pred_target = '0;
    logic [CW-1:0] pred_dur = '0;
    logic          db_valid = 1'b0;
    logic          db_pred = 1'b0;
    logic [AW-1:0] db_target = '0;
    logic [CW-1:0] db_defer = '0;
    logic          db_hit = 1'b0;
    logic          ob_resolve = 1'b0;
    logic [2:0]    act_o;
    logic          redir_valid_o;
    logic [AW-1:0] redir_target_o;
    logic          pend_valid_o;
    logic [AW-1:0] pend_target_o;
    logic [CW-1:0] pend_count_o;
    logic          xfer_o;
    logic          busy_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbr_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .pred_load(pred_load), .pred_target(pred_target), .pred_dur(pred_dur),
        .db_valid(db_valid), .db_pred(db_pred), .db_target(db_target),
        .db_defer(db_defer), .db_hit(db_hit), .ob_resolve(ob_resolve),
        .act_o(act_o), .redir_valid_o(redir_valid_o), .redir_target_o(redir_target_o),
        .pend_valid_o(pend_valid_o), .pend_target_o(pend_target_o),
        .pend_count_o(pend_count_o), .xfer_o(xfer_o), .busy_o(busy_o)
    );

    typedef struct packed {
        logic        pl;
        logic [15:0] pt;
        logic [5:0]  pd;
        logic        dv;
        logic        dp;
        logic [15:0] dt;
        logic [5:0]  dd;
        logic        hit;
        logic        ob;
        logic [2:0]  act;
        logic        rv;
        logic        pv;
        logic [15:0] tgt;
        logic [5:0]  cnt;
        logic        busy;
        logic        xf;
        logic [3:0]  req;
    } vec_t;

    // Inputs of one cycle, then the outputs expected after that edge.
    //            pl pt       pd  dv dp dt       dd  h  ob act rv pv tgt      cnt bsy xf req
    localparam vec_t VEC [0:25] = '{
        '{1'b1, 16'h0100, 6'd4, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0100,6'd4, 1'b0,1'b0,4'd2},  // R2 load
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0100,6'd3, 1'b0,1'b0,4'd2},  // R2 count
        '{1'b0, 16'h0000, 6'd0, 1'b1,1'b0,16'h0200,6'd1, 1'b0,1'b0, 3'd1,1'b0,1'b1,16'h0100,6'd2, 1'b0,1'b0,4'd3},  // R3 false predicate
        '{1'b0, 16'h0000, 6'd0, 1'b1,1'b1,16'h0100,6'd2, 1'b0,1'b0, 3'd2,1'b0,1'b1,16'h0100,6'd1, 1'b0,1'b0,4'd4},  // R4 agree
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0100,6'd0, 1'b0,1'b1,4'd2},  // R2 transfer
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0100,6'd0, 1'b0,1'b0,4'd2},  // R2 expired
        '{1'b0, 16'h0000, 6'd0, 1'b1,1'b1,16'h0300,6'd6, 1'b1,1'b0, 3'd3,1'b1,1'b1,16'h0300,6'd6, 1'b1,1'b0,4'd5},  // R5 none pending, hit
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0300,6'd5, 1'b1,1'b0,4'd7},  // R7
        '{1'b1, 16'h0400, 6'd9, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0300,6'd4, 1'b1,1'b0,4'd10}, // R10 load ignored
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0300,6'd3, 1'b0,1'b0,4'd7},  // R7 hit = 3
        '{1'b0, 16'h0000, 6'd0, 1'b1,1'b1,16'h0500,6'd1, 1'b0,1'b0, 3'd4,1'b1,1'b1,16'h0500,6'd1, 1'b1,1'b0,4'd6},  // R6 recover
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0500,6'd0, 1'b1,1'b1,4'd6},  // R6 transfer
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0500,6'd0, 1'b1,1'b0,4'd7},
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0500,6'd0, 1'b1,1'b0,4'd7},
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0500,6'd0, 1'b1,1'b0,4'd7},
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0500,6'd0, 1'b1,1'b0,4'd7},
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0500,6'd0, 1'b1,1'b0,4'd7},
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0500,6'd0, 1'b0,1'b0,4'd7},  // R7 recover = 7
        '{1'b1, 16'h0600, 6'd8, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0600,6'd8, 1'b0,1'b0,4'd2},  // R2 load
        '{1'b0, 16'h0000, 6'd0, 1'b1,1'b1,16'h0600,6'd9, 1'b0,1'b0, 3'd3,1'b1,1'b1,16'h0600,6'd9, 1'b1,1'b0,4'd5},  // R5 deferral differs, miss
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0600,6'd8, 1'b1,1'b0,4'd7},
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b1,16'h0600,6'd7, 1'b1,1'b0,4'd7},
        '{1'b0, 16'h0000, 6'd0, 1'b1,1'b1,16'h0700,6'd20,1'b1,1'b0, 3'd3,1'b1,1'b1,16'h0700,6'd20,1'b1,1'b0,4'd9},  // R9 replace
        '{1'b0, 16'h0000, 6'd0, 1'b1,1'b1,16'h0800,6'd2, 1'b0,1'b1, 3'd0,1'b0,1'b0,16'h0700,6'd20,1'b1,1'b0,4'd8},  // R8 ordinary wins
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0700,6'd20,1'b1,1'b0,4'd9},
        '{1'b0, 16'h0000, 6'd0, 1'b0,1'b0,16'h0000,6'd0, 1'b0,1'b0, 3'd0,1'b0,1'b0,16'h0700,6'd20,1'b0,1'b0,4'd9}   // R9 restarted hit = 3
    };

    task automatic chk(input string what, input int req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        pred_load = 1'b0; db_valid = 1'b0; db_pred = 1'b0; ob_resolve = 1'b0; db_hit = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state after reset edges
        chk("reset pend_valid", 1, 32'(pend_valid_o), 32'd0);
        chk("reset busy", 1, 32'(busy_o), 32'd0);
        chk("reset act", 1, 32'(act_o), 32'd0);
        chk("reset redirect", 1, 32'(redir_valid_o), 32'd0);
        chk("reset count", 1, 32'(pend_count_o), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 26; i++) begin
            pred_load   = VEC[i].pl;
            pred_target = 32'(VEC[i].pt);
            pred_dur    = VEC[i].pd;
            db_valid    = VEC[i].dv;
            db_pred     = VEC[i].dp;
            db_target   = 32'(VEC[i].dt);
            db_defer    = VEC[i].dd;
            db_hit      = VEC[i].hit;
            ob_resolve  = VEC[i].ob;
            step();
            chk($sformatf("row %0d act", i), int'(VEC[i].req), 32'(act_o), 32'(VEC[i].act));
            chk($sformatf("row %0d redirect", i), int'(VEC[i].req), 32'(redir_valid_o), 32'(VEC[i].rv));
            if (VEC[i].rv)
                chk($sformatf("row %0d redirect target", i), int'(VEC[i].req), redir_target_o, 32'(VEC[i].tgt));
            chk($sformatf("row %0d pend_valid", i), int'(VEC[i].req), 32'(pend_valid_o), 32'(VEC[i].pv));
            chk($sformatf("row %0d pend_target", i), int'(VEC[i].req), pend_target_o, 32'(VEC[i].tgt));
            chk($sformatf("row %0d pend_count", i), int'(VEC[i].req), 32'(pend_count_o), 32'(VEC[i].cnt));
            chk($sformatf("row %0d busy", i), int'(VEC[i].req), 32'(busy_o), 32'(VEC[i].busy));
            chk($sformatf("row %0d xfer", i), int'(VEC[i].req), 32'(xfer_o), 32'(VEC[i].xf));
        end
        idle_inputs();

        // R8: an ordinary branch leaves a predictor-installed prediction alone
        pred_load = 1'b1; pred_target = 32'h0900; pred_dur = 6'd5;
        step();
        pred_load = 1'b0; ob_resolve = 1'b1;
        step();
        ob_resolve = 1'b0;
        chk("ordinary keeps predictor valid", 8, 32'(pend_valid_o), 32'd1);
        chk("ordinary keeps predictor count", 8, 32'(pend_count_o), 32'd4);

        // R1: reset in the middle of a recovery clears everything
        db_valid = 1'b1; db_pred = 1'b1; db_target = 32'h0a00; db_defer = 6'd1; db_hit = 1'b0;
        step();
        idle_inputs();
        chk("recover before reset", 6, 32'(act_o), 32'd4);
        rst_n = 1'b0;
        step();
        chk("mid reset pend_valid", 1, 32'(pend_valid_o), 32'd0);
        chk("mid reset busy", 1, 32'(busy_o), 32'd0);
        chk("mid reset target", 1, pend_target_o, 32'd0);
        chk("mid reset redirect", 1, 32'(redir_valid_o), 32'd0);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule